// File: doc/BRIEF.md
# Low-power DRAM mode register file

This block holds the configuration registers of a low-power double-data-rate memory device and answers the status-read request. It watches a stream of already decoded commands, one per clock. A mode-register-set command is steered by the two bank-select bits to one of three targets. The basic mode register holds burst length, burst ordering and CAS latency. The extended mode register holds output drive strength and partial-array self-refresh coverage. The third target arms a status read, which is answered by the next READ.

Each field keeps its previous value when a reserved code is written to it. Such a write also raises a sticky error flag, which only reset clears. The stored self-refresh coverage is decoded into a per-bank refresh-enable mask and a highest-refreshed-row limit for the refresh engine.

The status word combines fixed device constants (density, width, revision, manufacturer code) with the 3-bit refresh multiplier from the temperature sensor. That multiplier is also decoded into too-cold and too-hot flags.

Top module: `lpdram_modereg`

## Requirements
- R1: After reset the block reports 2-beat bursts, sequential order, CAS latency 3, drive code 001 (half), coverage code 000 (all banks), no reserved-code error and no status output.
- R2: The command encoding is 00 NOP, 01 mode-register-set, 10 READ and 11 any other command. A mode-register-set with bank bits 00 loads the basic register from opcode bits [7:0]:
  - bits [2:0] give the burst length: 001 → 2, 010 → 4, 011 → 8 beats;
  - bit 3 gives the burst order: 1 → interleaved, 0 → sequential;
  - bits [6:4] give the CAS latency: 010 → 2, 011 → 3.
- R3: A mode-register-set with bank bits 10 loads the extended register:
  - bits [2:0] are the coverage code, accepted for 000, 001, 010, 101 and 110;
  - bits [7:5] are the drive code, accepted for 000 through 100.
- R4: A field written with a code outside its accepted set keeps its old value. The other fields of the same command still update. The write sets `reserved_err`, which stays high until reset.
- R5: `refresh_bank_en` has bit b set as follows: every bank for coverage 000; banks in the lower half of the bank range for 001; bank 0 only for 010, 101 and 110.
- R6: `refresh_row_max` is all ones for coverage 000, 001 and 010. Its top bit is cleared for 101. Its top two bits are cleared for 110.
- R7: A mode-register-set with bank bits 01 arms a status read. A READ while armed raises `status_valid` for exactly one cycle after that edge. The word is laid out as follows:
  - density in [15:13];
  - 0 in bit 12;
  - width flag in bit 11;
  - the sampled multiplier in [10:8];
  - revision in [7:4];
  - manufacturer code in [3:0].
- R8: The arm is cleared by the READ it answers and by any non-NOP command other than a bank-01 mode-register-set. NOPs leave it armed. A READ while not armed produces no status.
- R9: `temp_too_hot` is high when `temp_mult` is 111. `temp_too_cold` is high when `temp_mult` is 000 or 001. Both follow the input within the same cycle.
- R10: READ, other commands, NOPs and mode-register-sets with bank bits 11 leave every configuration field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | Decoded command: 00 NOP, 01 mode-register-set, 10 READ, 11 other |
| bank_sel | input | 2 | Bank-select bits sent with the command |
| mrs_op | input | 8 | Opcode bits sent with a mode-register-set |
| temp_mult | input | 3 | Refresh multiplier from the temperature sensor |
| bl_beats | output | 4 | Burst length in beats (2, 4 or 8) |
| burst_interleave | output | 1 | 1 for interleaved burst order |
| cas_lat | output | 2 | CAS latency in cycles (2 or 3) |
| drive_code | output | 3 | Stored drive-strength code |
| pasr_code | output | 3 | Stored self-refresh coverage code |
| refresh_bank_en | output | NUM_BANKS | Per-bank self-refresh enable |
| refresh_row_max | output | ROW_W | Highest row refreshed in enabled banks |
| reserved_err | output | 1 | Sticky flag for a reserved-code write |
| status_valid | output | 1 | Status word valid this cycle |
| status_word | output | 16 | Status word |
| temp_too_cold | output | 1 | Multiplier reports low temperature out of range |
| temp_too_hot | output | 1 | Multiplier reports high temperature out of range |

## Verification
The bench builds the block with four banks and a 14-bit row. With four banks the lower-half coverage mask (0011) is distinct from the single-bank mask (0001). With 14 rows bits the one-bit and two-bit row limits (1FFF and 0FFF) are distinct from all ones. Revision 5 and manufacturer code 9 are chosen so that every nibble of the status word differs from its neighbours. A swapped or shifted field in the word therefore shows up in the comparison. Every coverage and drive code, including the reserved ones, is driven in turn. The status arm is exercised across NOP gaps, interposed commands and repeated arming.

// File: rtl/lpdram_mr_pkg.sv
package lpdram_mr_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_MRS   = 2'b01,
    OP_READ  = 2'b10,
    OP_OTHER = 2'b11
  } cmd_op_e;

  localparam logic [1:0] TGT_BASE = 2'b00;
  localparam logic [1:0] TGT_STAT = 2'b01;
  localparam logic [1:0] TGT_EXT  = 2'b10;

  // Reset codes
  localparam logic [2:0] BL_RST   = 3'b001;
  localparam logic [2:0] CL_RST   = 3'b011;
  localparam logic [2:0] DS_RST   = 3'b001;
  localparam logic [2:0] PASR_RST = 3'b000;

  function automatic logic bl_ok(input logic [2:0] c);
    return (c == 3'b001) || (c == 3'b010) || (c == 3'b011);
  endfunction

  function automatic logic [3:0] bl_to_beats(input logic [2:0] c);
    return 4'd1 << c[1:0];
  endfunction

  function automatic logic cl_ok(input logic [2:0] c);
    return (c == 3'b010) || (c == 3'b011);
  endfunction

  function automatic logic ds_ok(input logic [2:0] c);
    return c <= 3'b100;
  endfunction

  function automatic logic pasr_ok(input logic [2:0] c);
    return (c == 3'b000) || (c == 3'b001) || (c == 3'b010) ||
           (c == 3'b101) || (c == 3'b110);
  endfunction

  // Is bank b refreshed under coverage code c, with nb banks in total
  function automatic logic pasr_bank_on(input logic [2:0] c, input int b, input int nb);
    if (c == 3'b000) return 1'b1;
    if (c == 3'b001) return b < (nb / 2);
    return b == 0;
  endfunction

  // Number of top row bits forced to zero by coverage code c
  function automatic logic [1:0] pasr_row_cut(input logic [2:0] c);
    if (c == 3'b101) return 2'd1;
    if (c == 3'b110) return 2'd2;
    return 2'd0;
  endfunction

endpackage

// File: rtl/lpdram_base_mr.sv
module lpdram_base_mr
  import lpdram_mr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [6:0] op,
  output logic [2:0] bl_code,
  output logic       bt_q,
  output logic [2:0] cl_code,
  output logic       err_q
);

  logic bl_bad, cl_bad;
  assign bl_bad = !bl_ok(op[2:0]);
  assign cl_bad = !cl_ok(op[6:4]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bl_code <= BL_RST;
      bt_q    <= 1'b0;
      cl_code <= CL_RST;
      err_q   <= 1'b0;
    end else if (wr_en) begin
      if (!bl_bad) bl_code <= op[2:0];
      bt_q <= op[3];
      if (!cl_bad) cl_code <= op[6:4];
      if (bl_bad || cl_bad) err_q <= 1'b1;
    end
  end

endmodule

// File: rtl/lpdram_ext_mr.sv
module lpdram_ext_mr
  import lpdram_mr_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [7:0]           op,
  output logic [2:0]           ds_q,
  output logic [2:0]           pasr_q,
  output logic                 err_q,
  output logic [NUM_BANKS-1:0] bank_en,
  output logic [ROW_W-1:0]     row_max
);

  localparam logic [ROW_W-1:0] ROW_ALL = {ROW_W{1'b1}};

  logic ds_bad, pasr_bad;
  assign ds_bad   = !ds_ok(op[7:5]);
  assign pasr_bad = !pasr_ok(op[2:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ds_q   <= DS_RST;
      pasr_q <= PASR_RST;
      err_q  <= 1'b0;
    end else if (wr_en) begin
      if (!ds_bad) ds_q <= op[7:5];
      if (!pasr_bad) pasr_q <= op[2:0];
      if (ds_bad || pasr_bad) err_q <= 1'b1;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_en[b] = pasr_bank_on(pasr_q, b, NUM_BANKS);
  end

  assign row_max = ROW_ALL >> pasr_row_cut(pasr_q);

endmodule

// File: rtl/lpdram_status_rd.sv
module lpdram_status_rd
  import lpdram_mr_pkg::*;
#(
  parameter logic [2:0] DENSITY_CODE = 3'b010,
  parameter bit         WIDTH32      = 1'b1,
  parameter logic [3:0] REV_ID       = 4'h0,
  parameter logic [3:0] MFR_ID       = 4'h3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cmd_op,
  input  logic [1:0]  bank_sel,
  input  logic [2:0]  temp_mult,
  output logic        armed_q,
  output logic        valid_q,
  output logic [15:0] word_q
);

  logic arm_set, hit;
  assign arm_set = (cmd_op == OP_MRS) && (bank_sel == TGT_STAT);
  assign hit     = (cmd_op == OP_READ) && armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      valid_q <= hit;
      if (hit) word_q <= {DENSITY_CODE, 1'b0, WIDTH32, temp_mult, REV_ID, MFR_ID};
      if (cmd_op != OP_NOP) armed_q <= arm_set;
    end
  end

endmodule

// File: rtl/lpdram_modereg.sv
module lpdram_modereg
  import lpdram_mr_pkg::*;
#(
  parameter int         NUM_BANKS    = 4,
  parameter int         ROW_W        = 14,
  parameter logic [2:0] DENSITY_CODE = 3'b010,
  parameter bit         WIDTH32      = 1'b1,
  parameter logic [3:0] REV_ID       = 4'h0,
  parameter logic [3:0] MFR_ID       = 4'h3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cmd_op,
  input  logic [1:0]           bank_sel,
  input  logic [7:0]           mrs_op,
  input  logic [2:0]           temp_mult,
  output logic [3:0]           bl_beats,
  output logic                 burst_interleave,
  output logic [1:0]           cas_lat,
  output logic [2:0]           drive_code,
  output logic [2:0]           pasr_code,
  output logic [NUM_BANKS-1:0] refresh_bank_en,
  output logic [ROW_W-1:0]     refresh_row_max,
  output logic                 reserved_err,
  output logic                 status_valid,
  output logic [15:0]          status_word,
  output logic                 temp_too_cold,
  output logic                 temp_too_hot
);

  // Named internal events, visible to the bound checker
  logic       base_wr, ext_wr, stat_armed;
  logic       base_err, ext_err;
  logic [2:0] bl_code, cl_code;

  assign base_wr = (cmd_op == OP_MRS) && (bank_sel == TGT_BASE);
  assign ext_wr  = (cmd_op == OP_MRS) && (bank_sel == TGT_EXT);

  lpdram_base_mr u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (base_wr),
    .op      (mrs_op[6:0]),
    .bl_code (bl_code),
    .bt_q    (burst_interleave),
    .cl_code (cl_code),
    .err_q   (base_err)
  );

  lpdram_ext_mr #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W)
  ) u_ext (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ext_wr),
    .op      (mrs_op),
    .ds_q    (drive_code),
    .pasr_q  (pasr_code),
    .err_q   (ext_err),
    .bank_en (refresh_bank_en),
    .row_max (refresh_row_max)
  );

  lpdram_status_rd #(
    .DENSITY_CODE (DENSITY_CODE),
    .WIDTH32      (WIDTH32),
    .REV_ID       (REV_ID),
    .MFR_ID       (MFR_ID)
  ) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_op    (cmd_op),
    .bank_sel  (bank_sel),
    .temp_mult (temp_mult),
    .armed_q   (stat_armed),
    .valid_q   (status_valid),
    .word_q    (status_word)
  );

  assign bl_beats      = bl_to_beats(bl_code);
  assign cas_lat       = cl_code[1:0];
  assign reserved_err  = base_err | ext_err;
  assign temp_too_hot  = (temp_mult == 3'b111);
  assign temp_too_cold = (temp_mult[2:1] == 2'b00);

endmodule

// File: rtl/lpdram_modereg_chk.sv
module lpdram_modereg_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           cmd_op,
  input logic                 base_wr,
  input logic                 ext_wr,
  input logic [3:0]           bl_beats,
  input logic                 burst_interleave,
  input logic [1:0]           cas_lat,
  input logic [2:0]           drive_code,
  input logic [2:0]           pasr_code,
  input logic [NUM_BANKS-1:0] refresh_bank_en,
  input logic                 reserved_err,
  input logic                 status_valid,
  input logic                 temp_too_cold,
  input logic                 temp_too_hot
);

  // R10
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !base_wr |=> ($stable(bl_beats) && $stable(burst_interleave) && $stable(cas_lat)));

  // R10
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_wr |=> ($stable(drive_code) && $stable(pasr_code)));

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reserved_err |=> reserved_err);

  // R7
  status_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |=> !status_valid);

  // R7
  status_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_valid) |-> $past(cmd_op == 2'b10));

  // R2
  bl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(bl_beats) == 1) && !bl_beats[0]);

  // R5
  bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_bank_en[0]);

  // R9
  temp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(temp_too_cold && temp_too_hot));

endmodule

bind lpdram_modereg lpdram_modereg_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .cmd_op           (cmd_op),
  .base_wr          (base_wr),
  .ext_wr           (ext_wr),
  .bl_beats         (bl_beats),
  .burst_interleave (burst_interleave),
  .cas_lat          (cas_lat),
  .drive_code       (drive_code),
  .pasr_code        (pasr_code),
  .refresh_bank_en  (refresh_bank_en),
  .reserved_err     (reserved_err),
  .status_valid     (status_valid),
  .temp_too_cold    (temp_too_cold),
  .temp_too_hot     (temp_too_hot)
);

// File: tb/lpdram_modereg_tb.sv
`timescale 1ns/1ps
module lpdram_modereg_tb;

  localparam int NB   = 4;
  localparam int RW   = 14;
  localparam int DENS = 2;
  localparam int REV  = 5;
  localparam int MFR  = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cmd_op = 2'b00;
  logic [1:0]    bank_sel = 2'b00;
  logic [7:0]    mrs_op = 8'h00;
  logic [2:0]    temp_mult = 3'd4;
  logic [3:0]    bl_beats;
  logic          burst_interleave;
  logic [1:0]    cas_lat;
  logic [2:0]    drive_code, pasr_code;
  logic [NB-1:0] refresh_bank_en;
  logic [RW-1:0] refresh_row_max;
  logic          reserved_err, status_valid, temp_too_cold, temp_too_hot;
  logic [15:0]   status_word;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  run = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  lpdram_modereg #(
    .NUM_BANKS(NB), .ROW_W(RW), .DENSITY_CODE(3'(DENS)), .WIDTH32(1'b1),
    .REV_ID(4'(REV)), .MFR_ID(4'(MFR))
  ) u_dut (.*);

  // Behavioural reference model
  int m_bl, m_cl, m_ds, m_pasr;
  bit m_bt, m_err, m_arm, m_sv;
  int m_sw;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_bl = 2; m_bt = 0; m_cl = 3; m_ds = 1; m_pasr = 0;
      m_err = 0; m_arm = 0; m_sv = 0; m_sw = 0;
    end else begin
      m_sv = (cmd_op == 2'b10) && m_arm;
      if (m_sv) m_sw = DENS * 8192 + 2048 + int'(temp_mult) * 256 + REV * 16 + MFR;
      if (cmd_op == 2'b01 && bank_sel == 2'b00) begin
        case (mrs_op[2:0])
          3'd1: m_bl = 2;
          3'd2: m_bl = 4;
          3'd3: m_bl = 8;
          default: m_err = 1;
        endcase
        m_bt = mrs_op[3];
        if (mrs_op[6:4] == 3'd2 || mrs_op[6:4] == 3'd3) m_cl = int'(mrs_op[6:4]);
        else m_err = 1;
      end
      if (cmd_op == 2'b01 && bank_sel == 2'b10) begin
        if (int'(mrs_op[7:5]) < 5) m_ds = int'(mrs_op[7:5]);
        else m_err = 1;
        if (mrs_op[2:0] inside {3'd0, 3'd1, 3'd2, 3'd5, 3'd6}) m_pasr = int'(mrs_op[2:0]);
        else m_err = 1;
      end
      if (cmd_op != 2'b00) m_arm = (cmd_op == 2'b01 && bank_sel == 2'b01);
    end
  end

  function automatic int exp_mask();
    int r = 0;
    for (int b = 0; b < NB; b++) begin
      bit on = (m_pasr == 0) ? 1'b1 : (m_pasr == 1) ? (b < NB / 2) : (b == 0);
      if (on) r += (1 << b);
    end
    return r;
  endfunction

  function automatic int exp_row();
    int full = (1 << RW) - 1;
    if (m_pasr == 5) return full / 2;
    if (m_pasr == 6) return full / 4;
    return full;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (run && rst_n) begin
      eq("R2", "bl_beats", int'(bl_beats), m_bl);
      eq("R2", "burst_interleave", int'(burst_interleave), int'(m_bt));
      eq("R2", "cas_lat", int'(cas_lat), m_cl);
      eq("R3", "drive_code", int'(drive_code), m_ds);
      eq("R3", "pasr_code", int'(pasr_code), m_pasr);
      eq("R4", "reserved_err", int'(reserved_err), int'(m_err));
      eq("R5", "refresh_bank_en", int'(refresh_bank_en), exp_mask());
      eq("R6", "refresh_row_max", int'(refresh_row_max), exp_row());
      eq("R7", "status_valid", int'(status_valid), int'(m_sv));
      if (m_sv) eq("R7", "status_word", int'(status_word), m_sw);
      eq("R9", "temp_too_hot", int'(temp_too_hot), int'(temp_mult == 3'd7));
      eq("R9", "temp_too_cold", int'(temp_too_cold), int'(temp_mult < 3'd2));
    end
  end

  task automatic cyc(input logic [1:0] op, input logic [1:0] bk, input logic [7:0] a, input logic [2:0] t);
    cmd_op = op; bank_sel = bk; mrs_op = a; temp_mult = t;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmd_op = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic reset_checks();
    // R1
    eq("R1", "bl_beats", int'(bl_beats), 2);
    eq("R1", "burst_interleave", int'(burst_interleave), 0);
    eq("R1", "cas_lat", int'(cas_lat), 3);
    eq("R1", "drive_code", int'(drive_code), 1);
    eq("R1", "pasr_code", int'(pasr_code), 0);
    eq("R1", "reserved_err", int'(reserved_err), 0);
    eq("R1", "status_valid", int'(status_valid), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [3:0] sv_bl;
    logic [2:0] sv_ds;
    do_reset();
    @(negedge clk);
    reset_checks();
    run = 1;

    // R2 base register patterns
    cyc(2'b01, 2'b00, 8'h2A, 3'd4);   // 4 beats, interleave, CL2
    cyc(2'b01, 2'b00, 8'h33, 3'd4);   // 8 beats, sequential, CL3
    // R4 reserved length with legal latency, then legal length with reserved latency
    cyc(2'b01, 2'b00, 8'h20, 3'd4);
    eq("R4", "bl kept on reserved code", int'(bl_beats), 8);
    eq("R4", "cl updated alongside", int'(cas_lat), 2);
    cyc(2'b01, 2'b00, 8'h71, 3'd4);
    eq("R4", "cl kept on reserved code", int'(cas_lat), 2);
    cyc(2'b01, 2'b00, 8'h0B, 3'd4);
    eq("R4", "err stays set", int'(reserved_err), 1);

    // R3 R5 R6 every coverage and drive code
    for (int i = 0; i < 8; i++) cyc(2'b01, 2'b10, 8'((i << 5) | i), 3'd4);
    cyc(2'b01, 2'b10, 8'h81, 3'd4);
    cyc(2'b01, 2'b10, 8'h25, 3'd4);
    cyc(2'b01, 2'b10, 8'h06, 3'd4);

    // R10 commands that must not touch the fields
    sv_bl = bl_beats; sv_ds = drive_code;
    cyc(2'b01, 2'b11, 8'hFF, 3'd4);
    cyc(2'b11, 2'b00, 8'h01, 3'd4);
    cyc(2'b10, 2'b10, 8'h00, 3'd4);
    cyc(2'b00, 2'b00, 8'h12, 3'd4);
    eq("R10", "bl after non-writes", int'(bl_beats), int'(sv_bl));
    eq("R10", "drive after non-writes", int'(drive_code), int'(sv_ds));

    // R7 R8 status read
    cyc(2'b01, 2'b01, 8'h00, 3'd3);
    cyc(2'b10, 2'b00, 8'h00, 3'd3);
    eq("R7", "status after armed read", int'(status_valid), 1);
    cyc(2'b10, 2'b00, 8'h00, 3'd3);
    eq("R8", "second read unarmed", int'(status_valid), 0);
    cyc(2'b01, 2'b01, 8'h00, 3'd6);
    cyc(2'b00, 2'b00, 8'h00, 3'd6);
    cyc(2'b00, 2'b00, 8'h00, 3'd6);
    cyc(2'b10, 2'b00, 8'h00, 3'd6);
    eq("R8", "arm kept over NOPs", int'(status_valid), 1);
    cyc(2'b01, 2'b01, 8'h00, 3'd2);
    cyc(2'b11, 2'b00, 8'h00, 3'd2);
    cyc(2'b10, 2'b00, 8'h00, 3'd2);
    eq("R8", "arm cleared by other cmd", int'(status_valid), 0);
    cyc(2'b01, 2'b01, 8'h00, 3'd2);
    cyc(2'b01, 2'b00, 8'h13, 3'd2);
    cyc(2'b10, 2'b00, 8'h00, 3'd2);
    eq("R8", "arm cleared by other MRS", int'(status_valid), 0);
    cyc(2'b01, 2'b01, 8'h00, 3'd7);
    cyc(2'b01, 2'b01, 8'h00, 3'd7);
    cyc(2'b10, 2'b00, 8'h00, 3'd7);
    eq("R8", "rearm then read", int'(status_valid), 1);

    // R9 sensor codes
    for (int t = 0; t < 8; t++) cyc(2'b00, 2'b00, 8'h00, 3'(t));

    // R1 R4 reset clears the sticky flag and restores defaults
    run = 0;
    do_reset();
    @(negedge clk);
    reset_checks();
    run = 1;
    cyc(2'b00, 2'b00, 8'h00, 3'd4);

    finish_run();
  end

endmodule